// File: doc/BRIEF.md
# Card Command Response Capture FIFO

This block sits behind the command line of a memory-card host. When the host issues a command it pulses `cmdStart` with the expected response type. The block then watches a serial response stream, one bit per strobe of `respValid`. It waits for the start bit, counting strobes against a programmable timeout limit. It shifts the response into 16-bit words and queues them in a small FIFO. It raises a sticky completion flag when the response ends or the wait expires.

A two-bit type code chooses what is captured and checked:
- A short response is 48 bits. All 48 frame bits are kept, so software reads three words and rebuilds the 32-bit argument as `w0<<24 | w1<<8 | w2>>8`.
- A long response is 136 bits. Its first eight bits are dropped and the remaining 128 bits fill eight words, most significant word first.
- Only the short type with checking compares the received 7-bit CRC against one computed over the first 40 frame bits.

The host drains the words through a single read port, and pops one word per `rdEn`.

Top module: `rsp_capture_fifo`

## Requirements
- R1: With type code 0, `respDone` is 1 in the cycle after `cmdStart`, both error flags are 0, and the FIFO stays empty (`rdData` reads 0).
- R2: With type code 1 or 3, the 48 frame bits are stored as three 16-bit words in arrival order. The first bit received is bit 15 of word 0. `respDone` is set after the 48th bit.
- R3: With type code 1, `crcErr` is set at completion when frame bits 7..1 differ from the CRC-7 (x^7+x^3+1, zero initial value) of frame bits 47..8. A matching CRC leaves `crcErr` at 0.
- R4: With type code 3, a wrong CRC field does not set `crcErr`.
- R5: With type code 2, the first 8 of the 136 bits are discarded. The remaining 128 bits fill eight words, most significant first, and `respDone` is set after bit 136.
- R6: While waiting for the start bit (a 0 on the line), each strobe that carries a 1 is counted. When the count reaches the timeout limit, `toErr` and `respDone` are set and no word is stored.
- R7: After reset the timeout limit is 255. A write with `toWrEn` replaces it with `toWrData`.
- R8: Reading while the FIFO is empty returns 0 and does not move the read pointer, so a later response is still read from its first word.
- R9: A new `cmdStart` clears `respDone`, `toErr`, `crcErr` and any unread words.
- R10: Bit values presented while `respValid` is 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmdStart | input | 1 | Pulse: a command has ended, begin expecting its response |
| cmdType | input | 2 | Response type code, sampled with cmdStart |
| respBit | input | 1 | Serial response line value |
| respValid | input | 1 | Strobe marking one card-clock bit time on respBit |
| toWrEn | input | 1 | Load the timeout limit |
| toWrData | input | 8 | New timeout limit in bit times |
| rdEn | input | 1 | Pop one word from the response FIFO |
| rdData | output | 16 | Word at the FIFO head, 0 when empty |
| respDone | output | 1 | Sticky end-of-response flag |
| toErr | output | 1 | Sticky response timeout flag |
| crcErr | output | 1 | Sticky response CRC mismatch flag |

## Verification
The bench builds the block with its default parameters. These are an 8-bit timeout counter that resets to 255 and an eight-word FIFO, which is exactly the depth a long response needs. With these values the bench can run the full reset-value timeout in a few hundred cycles, and can fill the FIFO to the brim with a 136-bit response. Random short responses use random index, argument, CRC corruption and strobe gaps. Directed cases cover the reset timeout boundary at 254 and 255 idle bits, a reprogrammed short limit, empty-FIFO reads, and abandoning unread words with a new command.

// File: rtl/rsp_capture_pkg.sv
package rsp_capture_pkg;

  typedef enum logic [1:0] {
    RSP_NONE      = 2'd0,
    RSP_SHORT_CRC = 2'd1,
    RSP_LONG      = 2'd2,
    RSP_SHORT     = 2'd3
  } rspType_e;

  localparam int IDX_W      = 8;
  localparam int LEN_SHORT  = 48;
  localparam int LEN_LONG   = 136;
  localparam int LONG_SKIP  = 8;
  localparam int CRC_W      = 7;
  localparam int CRC_SPAN   = LEN_SHORT - CRC_W - 1;
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

  typedef struct packed {
    logic clear;
    logic shiftEn;
    logic shiftBit;
  } dpStrobe_t;

endpackage

// File: rtl/rsp_capture_ctrl.sv
module rsp_capture_ctrl
  import rsp_capture_pkg::*;
#(
  parameter int          TO_W   = 8,
  parameter logic [TO_W-1:0] TO_RST = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmdStart,
  input  logic [1:0]      cmdType,
  input  logic            respBit,
  input  logic            respValid,
  input  logic            toWrEn,
  input  logic [TO_W-1:0] toWrData,
  output dpStrobe_t       dp,
  output logic            respDone,
  output logic            toErr,
  output logic            crcErr
);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RECV} state_e;

  localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(LEN_SHORT - 1);
  localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(LEN_LONG - 1);
  localparam logic [IDX_W-1:0] CRC_END    = IDX_W'(CRC_SPAN);
  localparam logic [IDX_W-1:0] CRC_RX_END = IDX_W'(CRC_SPAN + CRC_W);
  localparam logic [IDX_W-1:0] SKIP_IDX   = IDX_W'(LONG_SKIP);

  state_e           state;
  rspType_e         curType;
  logic [IDX_W-1:0] bitIdx;
  logic [TO_W-1:0]  waitCnt;
  logic [TO_W-1:0]  toLimit;
  logic [CRC_W-1:0] crcCalc;
  logic [CRC_W-1:0] crcRx;
  logic [CRC_W-1:0] crcNext;
  logic [IDX_W-1:0] lastIdx;
  logic             feedBack;

  assign feedBack = respBit ^ crcCalc[CRC_W-1];
  assign crcNext  = {crcCalc[CRC_W-2:0], 1'b0} ^ (feedBack ? CRC_POLY : '0);
  assign lastIdx  = (curType == RSP_LONG) ? LAST_LONG : LAST_SHORT;

  always_comb begin
    dp.clear    = cmdStart;
    dp.shiftBit = respBit;
    dp.shiftEn  = 1'b0;
    if (!cmdStart && respValid) begin
      if (state == ST_WAIT)
        dp.shiftEn = !respBit && (curType != RSP_LONG);
      else if (state == ST_RECV)
        dp.shiftEn = (curType != RSP_LONG) || (bitIdx >= SKIP_IDX);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      curType  <= RSP_NONE;
      bitIdx   <= '0;
      waitCnt  <= '0;
      toLimit  <= TO_RST;
      crcCalc  <= '0;
      crcRx    <= '0;
      respDone <= 1'b0;
      toErr    <= 1'b0;
      crcErr   <= 1'b0;
    end else begin
      if (toWrEn) toLimit <= toWrData;
      if (cmdStart) begin
        curType  <= rspType_e'(cmdType);
        bitIdx   <= '0;
        waitCnt  <= '0;
        crcCalc  <= '0;
        crcRx    <= '0;
        toErr    <= 1'b0;
        crcErr   <= 1'b0;
        respDone <= (cmdType == RSP_NONE);
        state    <= (cmdType == RSP_NONE) ? ST_IDLE : ST_WAIT;
      end else if (respValid) begin
        case (state)
          ST_WAIT: begin
            if (!respBit) begin
              state   <= ST_RECV;
              bitIdx  <= IDX_W'(1);
              crcCalc <= crcNext;
            end else if (waitCnt + TO_W'(1) == toLimit) begin
              toErr    <= 1'b1;
              respDone <= 1'b1;
              state    <= ST_IDLE;
            end else begin
              waitCnt <= waitCnt + TO_W'(1);
            end
          end
          ST_RECV: begin
            bitIdx <= bitIdx + IDX_W'(1);
            if (bitIdx < CRC_END) crcCalc <= crcNext;
            else if (bitIdx < CRC_RX_END) crcRx <= {crcRx[CRC_W-2:0], respBit};
            if (bitIdx == lastIdx) begin
              state    <= ST_IDLE;
              respDone <= 1'b1;
              if (curType == RSP_SHORT_CRC && crcRx != crcCalc) crcErr <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_type0_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdStart && cmdType == 2'd0) |=> (respDone && !toErr && !crcErr));

  p_crc_type_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crcErr) |-> (curType == RSP_SHORT_CRC));

  p_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(toErr && crcErr));

  p_clear_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdStart && cmdType != 2'd0) |=> (!respDone && !toErr && !crcErr));

endmodule

// File: rtl/rsp_capture_fifo_dp.sv
module rsp_capture_fifo_dp
  import rsp_capture_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         dp,
  input  logic              rdEn,
  output logic [WORD_W-1:0] rdData
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] shifter;
  logic [WORD_W-1:0] shiftNext;
  logic [BIT_W-1:0]  bitCnt;
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              push, pop, empty;

  assign shiftNext = {shifter[WORD_W-2:0], dp.shiftBit};
  assign push      = dp.shiftEn && (bitCnt == BIT_LAST);
  assign empty     = (count == '0);
  assign pop       = rdEn && !empty && !dp.clear;
  assign rdData    = empty ? '0 : mem[rdPtr];

  always_ff @(posedge clk) begin
    if (push && !dp.clear) mem[wrPtr] <= shiftNext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shifter <= '0;
      bitCnt  <= '0;
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
    end else if (dp.clear) begin
      shifter <= '0;
      bitCnt  <= '0;
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
    end else begin
      if (dp.shiftEn) begin
        shifter <= shiftNext;
        bitCnt  <= bitCnt + BIT_W'(1);
      end
      if (push) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + PTR_W'(1);
      if (pop)  rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + PTR_W'(1);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && !pop && count == CNT_W'(DEPTH)));

  p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && empty && !dp.clear) |=> $stable(rdPtr));

endmodule

// File: rtl/rsp_capture_fifo.sv
module rsp_capture_fifo
  import rsp_capture_pkg::*;
#(
  parameter int              TO_W   = 8,
  parameter logic [TO_W-1:0] TO_RST = '1,
  parameter int              WORD_W = 16,
  parameter int              DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmdStart,
  input  logic [1:0]        cmdType,
  input  logic              respBit,
  input  logic              respValid,
  input  logic              toWrEn,
  input  logic [TO_W-1:0]   toWrData,
  input  logic              rdEn,
  output logic [WORD_W-1:0] rdData,
  output logic              respDone,
  output logic              toErr,
  output logic              crcErr
);

  dpStrobe_t dp;

  rsp_capture_ctrl #(.TO_W(TO_W), .TO_RST(TO_RST)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdStart(cmdStart), .cmdType(cmdType),
    .respBit(respBit), .respValid(respValid), .toWrEn(toWrEn),
    .toWrData(toWrData), .dp(dp), .respDone(respDone), .toErr(toErr),
    .crcErr(crcErr)
  );

  rsp_capture_fifo_dp #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .dp(dp), .rdEn(rdEn), .rdData(rdData)
  );

endmodule

// File: tb/rsp_capture_fifo_bench.sv
module rsp_capture_fifo_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmdStart = 1'b0;
  logic [1:0]  cmdType = 2'd0;
  logic        respBit = 1'b1;
  logic        respValid = 1'b0;
  logic        toWrEn = 1'b0;
  logic [7:0]  toWrData = 8'd0;
  logic        rdEn = 1'b0;
  logic [15:0] rdData;
  logic        respDone, toErr, crcErr;

  int nChecks = 0;
  int nFail   = 0;
  int seed    = 1234;

  always #4 clk = ~clk;

  rsp_capture_fifo u_rsp_capture_fifo (
    .clk(clk), .rst_n(rst_n), .cmdStart(cmdStart), .cmdType(cmdType),
    .respBit(respBit), .respValid(respValid), .toWrEn(toWrEn),
    .toWrData(toWrData), .rdEn(rdEn), .rdData(rdData),
    .respDone(respDone), .toErr(toErr), .crcErr(crcErr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] crc7(input logic [39:0] d);
    logic [6:0] c = '0;
    for (int i = 39; i >= 0; i--) begin
      logic f = d[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (f) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [47:0] shortFrame(input logic [5:0] idx, input logic [31:0] arg, input bit bad);
    logic [39:0] head = {2'b00, idx, arg};
    logic [6:0]  c = crc7(head) ^ (bad ? 7'h01 : 7'h00);
    return {head, c, 1'b1};
  endfunction

  task automatic startCmd(input logic [1:0] t);
    @(negedge clk);
    cmdStart = 1'b1; cmdType = t;
    @(negedge clk);
    cmdStart = 1'b0;
  endtask

  task automatic sendBit(input logic b, input bit gaps);
    respValid = 1'b1; respBit = b;
    @(negedge clk);
    respValid = 1'b0;
    if (gaps) begin
      int g = $urandom_range(0, 2);
      for (int k = 0; k < g; k++) begin
        respBit = ~b;
        @(negedge clk);
      end
    end
    respBit = 1'b1;
  endtask

  task automatic idleBits(input int n);
    for (int k = 0; k < n; k++) sendBit(1'b1, 1'b0);
  endtask

  task automatic readWord(output logic [15:0] w);
    w = rdData;
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic runShort(input logic [1:0] t, input bit bad);
    logic [5:0]  idx = 6'($urandom);
    logic [31:0] arg = $urandom;
    logic [47:0] fr  = shortFrame(idx, arg, bad);
    logic [15:0] w0, w1, w2;
    logic [31:0] payload;
    startCmd(t);
    idleBits($urandom_range(0, 3));
    for (int i = 47; i >= 0; i--) sendBit(fr[i], 1'b1);
    check(respDone == 1'b1, "R2 done", 32'(respDone), 32'd1);
    if (t == 2'd1)
      check(crcErr == bad, "R3 crc flag", 32'(crcErr), 32'(bad));
    else
      check(crcErr == 1'b0, "R4 no crc check", 32'(crcErr), 32'd0);
    readWord(w0); readWord(w1); readWord(w2);
    check({w0, w1, w2} == fr, "R2 words", {8'd0, w0, w1[15:8]}, {8'd0, fr[47:24]});
    payload = (32'(w0) << 24) | (32'(w1) << 8) | (32'(w2) >> 8);
    check(payload == arg, "R2 payload", payload, arg);
  endtask

  logic [15:0] w;
  logic [135:0] lf;

  initial begin
    #(8 * 150000);
    nFail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!respDone && !toErr && !crcErr, "R7 reset flags", {respDone, toErr, crcErr}, 0);
    check(rdData == 16'd0, "R8 reset empty read", rdData, 0);

    // R7/R6: reset limit 255
    startCmd(2'd1);
    idleBits(254);
    check(!toErr && !respDone, "R7 no timeout at 254", {toErr, respDone}, 0);
    idleBits(1);
    check(toErr && respDone, "R6 R7 timeout at 255", {toErr, respDone}, 3);
    check(rdData == 16'd0, "R6 no word stored", rdData, 0);

    // R1
    startCmd(2'd0);
    check(respDone && !toErr && !crcErr, "R1 type0 done", {respDone, toErr, crcErr}, 4);
    check(rdData == 16'd0, "R1 empty", rdData, 0);

    // R7 write limit, R6 short limit
    @(negedge clk); toWrEn = 1'b1; toWrData = 8'd5;
    @(negedge clk); toWrEn = 1'b0;
    startCmd(2'd3);
    idleBits(4);
    check(!toErr, "R6 before limit", 32'(toErr), 0);
    idleBits(1);
    check(toErr && respDone, "R6 R7 written limit", {toErr, respDone}, 3);

    // R9: unread words dropped by a new command
    startCmd(2'd1);
    begin
      logic [47:0] fr = shortFrame(6'h11, 32'hCAFE1234, 1'b1);
      for (int i = 47; i >= 0; i--) sendBit(fr[i], 1'b0);
    end
    check(crcErr, "R3 bad crc directed", 32'(crcErr), 1);
    startCmd(2'd3);
    check(!respDone && !crcErr && rdData == 16'd0, "R9 clear", {respDone, crcErr, rdData}, 0);

    // R8 empty read then fresh response
    readWord(w); readWord(w);
    check(w == 16'd0, "R8 empty read zero", w, 0);
    begin
      logic [47:0] fr = shortFrame(6'h2A, 32'h89ABCDEF, 1'b0);
      for (int i = 47; i >= 0; i--) sendBit(fr[i], 1'b0);
      readWord(w);
      check(w == fr[47:32], "R8 first word after empty reads", w, fr[47:32]);
      readWord(w); readWord(w); readWord(w);
      check(w == 16'd0, "R8 read past end", w, 0);
    end

    // R2/R3/R4/R10 random short responses
    for (int n = 0; n < 40; n++) begin
      logic [1:0] t = ($urandom_range(0, 1) == 0) ? 2'd1 : 2'd3;
      runShort(t, $urandom_range(0, 3) == 0);
    end

    // R5 long responses
    for (int n = 0; n < 6; n++) begin
      lf = {2'b00, 6'h3F, 32'($urandom), 32'($urandom), 32'($urandom), 24'($urandom), 7'($urandom), 1'b1};
      startCmd(2'd2);
      idleBits($urandom_range(0, 3));
      for (int i = 135; i >= 0; i--) sendBit(lf[i], n[0]);
      check(respDone && !crcErr, "R5 long done", {respDone, crcErr}, 2);
      for (int k = 7; k >= 0; k--) begin
        readWord(w);
        check(w == lf[k*16 +: 16], "R5 long word R10", w, lf[k*16 +: 16]);
      end
      check(rdData == 16'd0, "R5 drained", rdData, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule